// File: doc/BRIEF.md
# Dual-Clock Mailbox Register

This block passes single 36-bit messages between two ports that run on unrelated clocks. The writing port stores a word on its own clock edge when it selects a write and the mailbox. It then holds an active-low full flag LOW until the reading side has taken the message. Any further write attempt while the flag is LOW is dropped, and the stored word does not change.

The reading port has its own active-low flag that goes LOW once the message has crossed into its domain. A mailbox read, sampled on the reader's clock edge, releases the message. The reader's flag returns HIGH at once, and the writer's flag returns HIGH a few writer cycles later.

The two domains exchange only two toggle bits, each through a two-flop synchronizer. The stored word is not synchronized, because it cannot change while a message is outstanding. One asynchronous active-low reset clears both domains, and its release is synchronized separately into each clock.

Top module: `mbx_xclk`

## Requirements
- R1: On a rising writer clock edge with `wr_rw_i`=1 (write), `wr_sel_i`=1 and `wr_full_n_o`=1, the word on `wr_data_i` is stored and `wr_full_n_o` is LOW right after that edge.
- R2: While `wr_full_n_o` is LOW, a writer edge with write and mailbox selected changes neither the stored word nor the flag.
- R3: On a rising reader clock edge with `rd_rw_i`=0 (read), `rd_sel_i`=1 and a message pending, `rd_full_n_o` is HIGH right after that edge. `wr_full_n_o` returns HIGH within 3 writer edges after it.
- R4: While and after reset, both flags are HIGH and the stored word reads as zero.
- R5: After an accepted write, `rd_full_n_o` goes LOW within 3 reader clock edges.
- R6: `rd_data_o` equals the stored word while `rd_rw_i`=0 and `rd_sel_i`=1, and is zero otherwise. While a message is pending, the word stays stable.
- R7: A writer edge with `wr_rw_i`=0 or `wr_sel_i`=0 stores nothing and leaves both flags HIGH.
- R8: A reader edge with `rd_rw_i`=1 or `rd_sel_i`=0 does not release a pending message.
- R9: A mailbox read while no message is pending has no effect: a later write is still held pending until a real read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_clk_i | input | 1 | Writer clock |
| wr_rw_i | input | 1 | Writer read/write select, 1 = write |
| wr_sel_i | input | 1 | Writer mailbox select |
| wr_data_i | input | 36 | Word to store |
| wr_full_n_o | output | 1 | Writer-side full flag, LOW = message outstanding |
| rd_clk_i | input | 1 | Reader clock |
| rd_rw_i | input | 1 | Reader read/write select, 0 = read |
| rd_sel_i | input | 1 | Reader mailbox select |
| rd_data_o | output | 36 | Stored word while a mailbox read is selected, else zero |
| rd_full_n_o | output | 1 | Reader-side flag, LOW = message waiting |

## Verification
The bench runs a 5 ns writer clock against a 7 ns reader clock so that the edges drift relative to each other. It goes after the following cases:
- A write attempted while the flag is LOW. A design without the lockout would overwrite the pending word, and the reader would see the newer data.
- Read and write strobes missing one of their two qualifiers. A design that decoded only one qualifier would store or release spuriously.
- A read issued with nothing pending. A design that toggled its release bit anyway would leave the two domains out of step, so the next message would be released immediately or the flag would stick.
- Flag latencies bounded in both directions. Extra or missing synchronizer stages show up as a bound miss.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_DATA_W = 36;
  localparam int unsigned MBX_SYNC_STAGES = 2;

  typedef enum logic {
    RW_READ  = 1'b0,
    RW_WRITE = 1'b1
  } rw_sel_e;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_bit_sync.sv
module mbx_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/mbx_wr_port.sv
module mbx_wr_port
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = MBX_DATA_W,
  parameter int unsigned SYNC_STAGES = MBX_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rw_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rel_tgl_i,   // from reader domain, asynchronous
  output logic              full_n_o,
  output logic              put_tgl_o,
  output logic [DATA_W-1:0] word_o
);
  logic              rel_tgl_s;
  logic              put_tgl_q;
  logic [DATA_W-1:0] word_q;
  logic              accept;

  mbx_bit_sync #(.STAGES(SYNC_STAGES)) u_rel_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rel_tgl_i),
    .q_o   (rel_tgl_s)
  );

  assign full_n_o = ~(put_tgl_q ^ rel_tgl_s);
  assign accept   = (rw_i == RW_WRITE) && sel_i && full_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      put_tgl_q <= 1'b0;
      word_q    <= '0;
    end else if (accept) begin
      put_tgl_q <= ~put_tgl_q;
      word_q    <= data_i;
    end
  end

  assign put_tgl_o = put_tgl_q;
  assign word_o    = word_q;

  p_write_takes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rw_i && sel_i && full_n_o) |=> (!full_n_o && word_o == $past(data_i)));

  p_blocked_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_n_o |=> $stable(word_o));

  p_no_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_n_o && !(rw_i && sel_i)) |=> full_n_o);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_flag_r4: assert (full_n_o && word_o == '0);
    end
  end
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = MBX_DATA_W,
  parameter int unsigned SYNC_STAGES = MBX_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rw_i,
  input  logic              sel_i,
  input  logic              put_tgl_i,   // from writer domain, asynchronous
  input  logic [DATA_W-1:0] word_i,      // quasi-static while pending
  output logic [DATA_W-1:0] data_o,
  output logic              full_n_o,
  output logic              rel_tgl_o
);
  logic put_tgl_s;
  logic rel_tgl_q;
  logic pending;
  logic rd_sel;

  mbx_bit_sync #(.STAGES(SYNC_STAGES)) u_put_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (put_tgl_i),
    .q_o   (put_tgl_s)
  );

  assign pending = put_tgl_s ^ rel_tgl_q;
  assign rd_sel  = (rw_i == RW_READ) && sel_i;

  // Release only a message that has arrived; keeps the toggles in step.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rel_tgl_q <= 1'b0;
    else if (rd_sel && pending) rel_tgl_q <= ~rel_tgl_q;
  end

  assign full_n_o  = ~pending;
  assign rel_tgl_o = rel_tgl_q;
  assign data_o    = rd_sel ? word_i : '0;

  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rw_i && sel_i && !full_n_o) |=> full_n_o);

  p_hold_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_n_o && (rw_i || !sel_i)) |=> !full_n_o);

  p_word_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_n_o && $past(!full_n_o)) |-> $stable(word_i));
endmodule

// File: rtl/mbx_xclk.sv
module mbx_xclk
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = MBX_DATA_W,
  parameter int unsigned SYNC_STAGES = MBX_SYNC_STAGES
) (
  input  logic              rst_ni,
  input  logic              wr_clk_i,
  input  logic              wr_rw_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_full_n_o,
  input  logic              rd_clk_i,
  input  logic              rd_rw_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_full_n_o
);
  logic              wr_rst_n, rd_rst_n;
  logic              put_tgl, rel_tgl;
  logic [DATA_W-1:0] word;

  mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .rst_no(wr_rst_n)
  );

  mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .rst_no(rd_rst_n)
  );

  mbx_wr_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .clk_i    (wr_clk_i),
    .rst_ni   (wr_rst_n),
    .rw_i     (wr_rw_i),
    .sel_i    (wr_sel_i),
    .data_i   (wr_data_i),
    .rel_tgl_i(rel_tgl),
    .full_n_o (wr_full_n_o),
    .put_tgl_o(put_tgl),
    .word_o   (word)
  );

  mbx_rd_port #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .clk_i    (rd_clk_i),
    .rst_ni   (rd_rst_n),
    .rw_i     (rd_rw_i),
    .sel_i    (rd_sel_i),
    .put_tgl_i(put_tgl),
    .word_i   (word),
    .data_o   (rd_data_o),
    .full_n_o (rd_full_n_o),
    .rel_tgl_o(rel_tgl)
  );
endmodule

// File: tb/mbx_xclk_tb_top.sv
`timescale 1ns/1ps
module mbx_xclk_tb_top;
  localparam int W = 36;

  logic         rst_ni = 1'b0;
  logic         wr_clk = 1'b0, rd_clk = 1'b0;
  logic         wr_rw = 1'b0, wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         wr_full_n;
  logic         rd_rw = 1'b1, rd_sel = 1'b0;
  logic [W-1:0] rd_data;
  logic         rd_full_n;

  int checks = 0, errors = 0;
  logic [W-1:0] model_word = '0;   // reference: last accepted word
  bit           model_pend = 0;    // reference: message outstanding (reader view)
  bit           done = 0;

  always #2.5 wr_clk = ~wr_clk;   // 200 MHz
  always #3.5 rd_clk = ~rd_clk;   // unrelated reader clock

  mbx_xclk dut_i (
    .rst_ni(rst_ni), .wr_clk_i(wr_clk), .wr_rw_i(wr_rw), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .wr_full_n_o(wr_full_n), .rd_clk_i(rd_clk),
    .rd_rw_i(rd_rw), .rd_sel_i(rd_sel), .rd_data_o(rd_data), .rd_full_n_o(rd_full_n)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the reference word while a read is selected.
  always begin
    @(negedge rd_clk); #1;
    if (rst_ni && model_pend && !rd_full_n && !rd_rw && rd_sel)
      chk(rd_data === model_word, "R6 monitor", rd_data, model_word);
  end

  task automatic wr_cycle(input bit rw, input bit sel, input logic [W-1:0] d);
    @(negedge wr_clk);
    wr_rw = rw; wr_sel = sel; wr_data = d;
    @(negedge wr_clk);
    wr_rw = 1'b0; wr_sel = 1'b0;
  endtask

  task automatic rd_idle(input int n);
    for (int i = 0; i < n; i++) @(negedge rd_clk);
  endtask

  // Accepted write: flag LOW after the edge, reader flag within 3 reader edges.
  task automatic send(input logic [W-1:0] d);
    int n;
    wr_cycle(1'b1, 1'b1, d);
    model_word = d;
    chk(wr_full_n === 1'b0, "R1 wr flag low", {35'd0, wr_full_n}, 36'd0);
    n = 0;
    while (rd_full_n !== 1'b0 && n < 8) begin @(negedge rd_clk); n++; end
    chk(rd_full_n === 1'b0 && n <= 3, "R5 rd flag latency", n, 3);
    model_pend = 1;
  endtask

  // Mailbox read: word visible before the edge, release after it.
  task automatic receive(input logic [W-1:0] exp);
    int n;
    @(negedge rd_clk);
    rd_rw = 1'b0; rd_sel = 1'b1;
    #1;
    chk(rd_data === exp, "R6 read data", rd_data, exp);
    @(negedge rd_clk);
    model_pend = 0;
    rd_rw = 1'b1; rd_sel = 1'b0;
    chk(rd_full_n === 1'b1, "R3 rd flag released", {35'd0, rd_full_n}, 36'd1);
    n = 0;
    while (wr_full_n !== 1'b1 && n < 8) begin @(negedge wr_clk); n++; end
    chk(wr_full_n === 1'b1 && n <= 3, "R3 wr flag latency", n, 3);
  endtask

  initial begin
    // R4: reset
    rd_idle(6);
    chk(wr_full_n === 1'b1 && rd_full_n === 1'b1, "R4 flags in reset", {34'd0, wr_full_n, rd_full_n}, 36'd3);
    @(negedge wr_clk); rst_ni = 1'b1;
    rd_idle(4);
    @(negedge rd_clk); rd_rw = 1'b0; rd_sel = 1'b1; #1;
    chk(rd_data === '0, "R4 word zero", rd_data, '0);
    chk(wr_full_n === 1'b1 && rd_full_n === 1'b1, "R4 flags after reset", {34'd0, wr_full_n, rd_full_n}, 36'd3);
    @(negedge rd_clk); rd_rw = 1'b1; rd_sel = 1'b0;

    // R7: half-qualified write strobes
    wr_cycle(1'b0, 1'b1, 36'hA_AAAA_AAAA);
    wr_cycle(1'b1, 1'b0, 36'h5_5555_5555);
    rd_idle(5);
    chk(wr_full_n === 1'b1 && rd_full_n === 1'b1, "R7 no store flags", {34'd0, wr_full_n, rd_full_n}, 36'd3);
    @(negedge rd_clk); rd_rw = 1'b0; rd_sel = 1'b1; #1;
    chk(rd_data === '0, "R7 word unchanged", rd_data, '0);
    @(negedge rd_clk); rd_rw = 1'b1; rd_sel = 1'b0;

    // R1/R5: first message
    send(36'h1_2345_6789);

    // R2: blocked write
    wr_cycle(1'b1, 1'b1, 36'hF_0F0F_0F0F);
    chk(wr_full_n === 1'b0, "R2 flag stays low", {35'd0, wr_full_n}, 36'd0);

    // R8: reader strobes missing a qualifier, R6 else branch
    @(negedge rd_clk); rd_rw = 1'b1; rd_sel = 1'b1;
    #1; chk(rd_data === '0, "R6 write select gives zero", rd_data, '0);
    @(negedge rd_clk); rd_rw = 1'b0; rd_sel = 1'b0;
    #1; chk(rd_data === '0, "R6 no select gives zero", rd_data, '0);
    @(negedge rd_clk); rd_rw = 1'b1;
    rd_idle(2);
    chk(rd_full_n === 1'b0 && wr_full_n === 1'b0, "R8 no release", {34'd0, wr_full_n, rd_full_n}, 36'd0);

    // R3 + R2: release, word must be the first one
    receive(36'h1_2345_6789);

    // R9: read with nothing pending
    @(negedge rd_clk); rd_rw = 1'b0; rd_sel = 1'b1;
    rd_idle(3);
    rd_rw = 1'b1; rd_sel = 1'b0;
    chk(rd_full_n === 1'b1 && wr_full_n === 1'b1, "R9 idle read no effect", {34'd0, wr_full_n, rd_full_n}, 36'd3);
    send(36'h8_0000_0001);
    rd_idle(6);
    chk(rd_full_n === 1'b0, "R9 message still pending", {35'd0, rd_full_n}, 36'd0);
    receive(36'h8_0000_0001);

    // Several more messages with varied patterns
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] v;
      v = {4'(k), 32'hC0DE_0000 + 32'(k * 32'h1111)};
      send(v);
      if (k % 2 == 1) begin
        wr_cycle(1'b1, 1'b1, ~v);
        chk(wr_full_n === 1'b0, "R2 repeat blocked", {35'd0, wr_full_n}, 36'd0);
      end
      receive(v);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge wr_clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule